// File: doc/BRIEF.md
# SIMD Element Reversal Unit

This unit mirrors the order of elements inside containers of a 64-bit or 128-bit SIMD operand. Each container is a 16, 32 or 64-bit slice. The caller picks the container width and the element width independently for each operation. Container width comes from a region code and element width from a size code. A quad flag chooses whether the whole 128-bit operand is processed or only its low 64 bits. The operation depends only on sizes, so the result is a fixed bit permutation of the operand.

The controls can come from dedicated input fields. They can also be pulled from a raw 32-bit instruction word, which also yields the destination and source register numbers. One operation is taken per cycle over a valid/ready handshake, and the result is registered one cycle after acceptance. When the element is not narrower than the container, or when a reserved code is used, the unit flags the operation as undefined and returns zero data.

Top module: `elem_rev_unit`

## Requirements
- R1: With region code 10 (16-bit containers) and size code 00 (8-bit elements), the two bytes of every halfword change places.
- R2: With region code 01 (32-bit containers), the 8-bit (size 00) or 16-bit (size 01) elements inside every 32-bit word appear in reverse order.
- R3: With region code 00 (64-bit containers), the 8-bit (size 00), 16-bit (size 01) or 32-bit (size 10) elements inside every 64-bit doubleword appear in reverse order.
- R4: Data content has no influence on routing. Every bit of the result is the operand bit chosen by the size codes alone, for any data pattern.
- R5: Quad flag 1 processes both 64-bit halves in the same way. Quad flag 0 processes only bits 63:0, drives result bits 127:64 to zero and ignores operand bits 127:64.
- R6: When in_sel_word is 1, the element size is taken from in_word bits 19:18, the region code from bits 8:7 and the quad flag from bit 6. In that case in_region, in_esize and in_quad have no effect.
- R7: out_dst equals {in_word[22], in_word[15:12]} and out_src equals {in_word[5], in_word[3:0]} of the accepted operation.
- R8: If either code is 11, or the element size is not smaller than the container, out_undef is 1 and out_data is all zero.
- R9: An operation accepted at a clock edge (in_valid and in_ready high) sets out_valid with its result at that same edge. The result is therefore visible in the following cycle.
- R10: While out_valid is 1 and out_ready is 0, in_ready is 0 and the output holds its value. An output taken in the same cycle as a new acceptance is replaced without a gap.
- R11: Applying the same legal operation twice returns the original operand, within the processed width.
- R12: After synchronous reset (rst_n low at a clock edge), out_valid, out_undef and out_data are zero and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit can take an operation this cycle |
| in_sel_word | input | 1 | 1: take controls from in_word; 0: from the dedicated fields |
| in_word | input | 32 | Raw instruction word (controls and register numbers) |
| in_region | input | 2 | Container code: 00=64, 01=32, 10=16 bits |
| in_esize | input | 2 | Element code: 00=8, 01=16, 10=32 bits |
| in_quad | input | 1 | 1: 128-bit operation, 0: 64-bit operation |
| in_data | input | 128 | Operand |
| out_valid | output | 1 | Result register holds an operation |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Reversed operand |
| out_undef | output | 1 | Operation was an unsupported combination |
| out_dst | output | 5 | Destination register number |
| out_src | output | 5 | Source register number |

## Verification
The assertions check the handshake on every cycle: single-cycle latency, holding under backpressure, blocking of new input while full, and zero data on undefined results. They also check zeroed upper halves for 64-bit operations, flagging of reserved codes, and the register-number fields. The lane routing for each container and element pairing, the involution property, the precedence of word fields over direct fields and the reset values need reference results. Only the bench scenarios can show those, comparing against an independently written element-index model.

// File: rtl/erev_pkg.sv
// Package: shared codes and constants of the element reversal unit.
// Assumes byte lanes and a largest container of 64 bits.
package erev_pkg;

    // Container selection code
    typedef enum logic [1:0] {
        CONT_64  = 2'b00,
        CONT_32  = 2'b01,
        CONT_16  = 2'b10,
        CONT_RSV = 2'b11
    } cont_e;

    // Element size code
    typedef enum logic [1:0] {
        ELEM_8   = 2'b00,
        ELEM_16  = 2'b01,
        ELEM_32  = 2'b10,
        ELEM_RSV = 2'b11
    } elem_e;

    // Field positions inside the raw instruction word
    localparam int WF_ESZ_LO  = 18;
    localparam int WF_CONT_LO = 7;
    localparam int WF_QUAD    = 6;
    localparam int WF_DST_HI  = 22;
    localparam int WF_DST_LO  = 12;
    localparam int WF_SRC_HI  = 5;
    localparam int WF_SRC_LO  = 0;

    // Register number width
    localparam int REGN_W = 5;

    // Lanes in the largest container (64 bits of byte lanes)
    localparam int GRP_LANES = 8;
    localparam int GRP_IDX_W = $clog2(GRP_LANES);

endpackage

// File: rtl/erev_decode.sv
// Module: erev_decode
// Picks the active control fields (raw word or direct inputs), checks the
// container/element pairing and turns it into a lane index XOR mask.
// Assumes power-of-two sizes so that reversal in a group equals index XOR.
module erev_decode
    import erev_pkg::*;
(
    input  logic                 sel_word,
    input  logic [31:0]          word,
    input  logic [1:0]           region,
    input  logic [1:0]           esize,
    input  logic                 quad,
    output logic [GRP_IDX_W-1:0] xor_mask,
    output logic                 legal,
    output logic                 quad_eff,
    output logic [REGN_W-1:0]    dst_num,
    output logic [REGN_W-1:0]    src_num
);

    logic [1:0]           cont_code;
    logic [1:0]           elem_code;
    logic [GRP_IDX_W-1:0] cont_mask;
    logic [GRP_IDX_W-1:0] elem_mask;
    logic                 codes_ok;

    // Select where the control fields come from
    always_comb begin
        if (sel_word) begin
            cont_code = word[WF_CONT_LO +: 2];
            elem_code = word[WF_ESZ_LO +: 2];
            quad_eff  = word[WF_QUAD];
        end else begin
            cont_code = region;
            elem_code = esize;
            quad_eff  = quad;
        end
    end

    // Lane index span of one container
    always_comb begin
        unique case (cont_e'(cont_code))
            CONT_16: cont_mask = GRP_IDX_W'(1);
            CONT_32: cont_mask = GRP_IDX_W'(3);
            CONT_64: cont_mask = GRP_IDX_W'(7);
            default: cont_mask = '0;
        endcase
    end

    // Lane index span of one element
    always_comb begin
        unique case (elem_e'(elem_code))
            ELEM_8:  elem_mask = GRP_IDX_W'(0);
            ELEM_16: elem_mask = GRP_IDX_W'(1);
            ELEM_32: elem_mask = GRP_IDX_W'(3);
            default: elem_mask = '0;
        endcase
    end

    // Legality: no reserved code and element strictly narrower than container
    always_comb begin
        codes_ok = (cont_code != CONT_RSV) && (elem_code != ELEM_RSV);
        legal    = codes_ok && (elem_mask < cont_mask);
        xor_mask = legal ? (cont_mask & ~elem_mask) : '0;
    end

    // Register numbers, upper bit stored apart from the rest
    always_comb begin
        dst_num = {word[WF_DST_HI], word[WF_DST_LO +: REGN_W-1]};
        src_num = {word[WF_SRC_HI], word[WF_SRC_LO +: REGN_W-1]};
    end

endmodule

// File: rtl/erev_permute.sv
// Module: erev_permute
// Byte-lane crossbar: every output lane reads the lane whose index inside the
// same 64-bit group differs by xor_mask. Upper half zeroed for 64-bit
// operations, all lanes zeroed for illegal operations.
// Assumes LANES is a multiple of GRP_LANES.
module erev_permute
    import erev_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 16,
    localparam int DATA_W  = LANE_W * LANES,
    localparam int HALF    = LANES / 2,
    localparam int LIDX_W  = $clog2(LANES)
) (
    input  logic [DATA_W-1:0]    data_in,
    input  logic [GRP_IDX_W-1:0] xor_mask,
    input  logic                 legal,
    input  logic                 quad_eff,
    output logic [DATA_W-1:0]    data_out
);

    logic [LANE_W-1:0] in_lane [LANES];

    genvar gi;
    generate
        for (gi = 0; gi < LANES; gi++) begin : g_lane
            localparam int BASE = gi - (gi % GRP_LANES);
            localparam int OFF  = gi % GRP_LANES;
            logic [GRP_IDX_W-1:0] off_sel;
            logic [LIDX_W-1:0]    src_idx;

            // Unpack the operand into lanes
            assign in_lane[gi] = data_in[gi*LANE_W +: LANE_W];

            // Source lane for this output lane
            always_comb begin
                off_sel = GRP_IDX_W'(OFF) ^ xor_mask;
                src_idx = LIDX_W'(BASE) + LIDX_W'(off_sel);
            end

            if (gi >= HALF) begin : g_upper
                // Upper lanes only live in 128-bit operations
                always_comb begin
                    if (legal && quad_eff)
                        data_out[gi*LANE_W +: LANE_W] = in_lane[src_idx];
                    else
                        data_out[gi*LANE_W +: LANE_W] = '0;
                end
            end else begin : g_lower
                // Lower lanes live whenever the operation is legal
                always_comb begin
                    if (legal)
                        data_out[gi*LANE_W +: LANE_W] = in_lane[src_idx];
                    else
                        data_out[gi*LANE_W +: LANE_W] = '0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/erev_outreg.sv
// Module: erev_outreg
// One-entry output register with valid/ready. Takes a new entry when empty
// or when the current one leaves in the same cycle.
module erev_outreg
    import erev_pkg::*;
#(
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] d_data,
    input  logic              d_undef,
    input  logic [REGN_W-1:0] d_dst,
    input  logic [REGN_W-1:0] d_src,
    output logic              q_valid,
    input  logic              q_ready,
    output logic [DATA_W-1:0] q_data,
    output logic              q_undef,
    output logic [REGN_W-1:0] q_dst,
    output logic [REGN_W-1:0] q_src
);

    logic take;

    // Acceptance rule
    always_comb begin
        in_ready = !q_valid || q_ready;
        take     = in_valid && in_ready;
    end

    // Occupancy flag
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_valid <= 1'b0;
        else if (take)
            q_valid <= 1'b1;
        else if (q_ready)
            q_valid <= 1'b0;
    end

    // Payload capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_data  <= '0;
            q_undef <= 1'b0;
            q_dst   <= '0;
            q_src   <= '0;
        end else if (take) begin
            q_data  <= d_data;
            q_undef <= d_undef;
            q_dst   <= d_dst;
            q_src   <= d_src;
        end
    end

endmodule

// File: rtl/elem_rev_unit.sv
// Module: elem_rev_unit (top)
// Reverses elements inside 16/32/64-bit containers of a SIMD operand and
// registers the result behind a valid/ready handshake.
// Assumes byte lanes; the largest container is 64 bits.
module elem_rev_unit
    import erev_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 16,
    localparam int DATA_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_sel_word,
    input  logic [31:0]       in_word,
    input  logic [1:0]        in_region,
    input  logic [1:0]        in_esize,
    input  logic              in_quad,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_undef,
    output logic [4:0]        out_dst,
    output logic [4:0]        out_src
);

    logic [GRP_IDX_W-1:0] xor_mask;
    logic                 legal;
    logic                 quad_eff;
    logic [REGN_W-1:0]    dst_num;
    logic [REGN_W-1:0]    src_num;
    logic [DATA_W-1:0]    perm_data;

    erev_decode u_decode (
        .sel_word (in_sel_word),
        .word     (in_word),
        .region   (in_region),
        .esize    (in_esize),
        .quad     (in_quad),
        .xor_mask (xor_mask),
        .legal    (legal),
        .quad_eff (quad_eff),
        .dst_num  (dst_num),
        .src_num  (src_num)
    );

    erev_permute #(
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) u_permute (
        .data_in  (in_data),
        .xor_mask (xor_mask),
        .legal    (legal),
        .quad_eff (quad_eff),
        .data_out (perm_data)
    );

    erev_outreg #(
        .DATA_W (DATA_W)
    ) u_outreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .d_data   (perm_data),
        .d_undef  (!legal),
        .d_dst    (dst_num),
        .d_src    (src_num),
        .q_valid  (out_valid),
        .q_ready  (out_ready),
        .q_data   (out_data),
        .q_undef  (out_undef),
        .q_dst    (out_dst),
        .q_src    (out_src)
    );

endmodule

// File: rtl/erev_checker.sv
// Module: erev_checker
// Port-level properties of elem_rev_unit, attached by bind below.
module erev_checker #(
    parameter int DATA_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_sel_word,
    input logic [31:0]       in_word,
    input logic [1:0]        in_region,
    input logic              in_quad,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_undef,
    input logic [4:0]        out_dst,
    input logic [4:0]        out_src
);

    logic       acc;
    logic       half_op;
    logic [1:0] cont_sel;

    // Observed acceptance and selected controls at the inputs
    always_comb begin
        acc      = in_valid && in_ready;
        half_op  = in_sel_word ? !in_word[6] : !in_quad;
        cont_sel = in_sel_word ? in_word[8:7] : in_region;
    end

    AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_undef |-> out_data == '0); // R8

    AST_RESERVED_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        acc && cont_sel == 2'b11 |=> out_undef); // R8

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_valid); // R9

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_undef)); // R10

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready); // R10

    AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        acc && half_op |=> out_data[DATA_W-1:DATA_W/2] == '0); // R5

    AST_REG_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_dst == {$past(in_word[22]), $past(in_word[15:12])}
                && out_src == {$past(in_word[5]), $past(in_word[3:0])}); // R7

endmodule

bind elem_rev_unit erev_checker #(.DATA_W(DATA_W)) u_erev_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_sel_word (in_sel_word),
    .in_word     (in_word),
    .in_region   (in_region),
    .in_quad     (in_quad),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_undef   (out_undef),
    .out_dst     (out_dst),
    .out_src     (out_src)
);

// File: tb/elem_rev_unit_bench.sv
`timescale 1ns/1ps
module elem_rev_unit_bench;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid, in_ready, in_sel_word, in_quad;
    logic [31:0]  in_word;
    logic [1:0]   in_region, in_esize;
    logic [127:0] in_data;
    logic         out_valid, out_ready, out_undef;
    logic [127:0] out_data;
    logic [4:0]   out_dst, out_src;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    logic [127:0] r_data;
    logic         r_undef;
    logic [4:0]   r_dst, r_src;

    localparam logic [127:0] PAT_IDX = 128'h0f0e0d0c_0b0a0908_07060504_03020100;
    localparam logic [127:0] PAT_MIX = 128'hdeadbeef_01234567_89abcdef_a5c3e187;

    always #2.5 clk = ~clk;

    elem_rev_unit u_elem_rev_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sel_word(in_sel_word), .in_word(in_word), .in_region(in_region),
        .in_esize(in_esize), .in_quad(in_quad), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_undef(out_undef), .out_dst(out_dst), .out_src(out_src)
    );

    // Record one check
    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int cont_bits(input logic [1:0] c);
        return (c == 2'b00) ? 64 : (c == 2'b01) ? 32 : 16;
    endfunction

    function automatic int elem_bits(input logic [1:0] e);
        return (e == 2'b00) ? 8 : (e == 2'b01) ? 16 : 32;
    endfunction

    // Element-index reference model
    function automatic logic [127:0] ref_rev(input logic [127:0] d, input logic [1:0] c,
                                             input logic [1:0] e, input logic q);
        logic [127:0] r = '0;
        int cb = cont_bits(c);
        int eb = elem_bits(e);
        int n  = cb / eb;
        int w  = q ? 128 : 64;
        for (int k = 0; k < w / cb; k++)
            for (int j = 0; j < n; j++)
                for (int b = 0; b < eb; b++)
                    r[k*cb + j*eb + b] = d[k*cb + (n-1-j)*eb + b];
        return r;
    endfunction

    function automatic logic [31:0] mk_word(input logic [1:0] esz, input logic [1:0] cont,
                                            input logic q, input logic [4:0] dst, input logic [4:0] src);
        logic [31:0] w = 32'hf3b00c10;
        w[19:18] = esz; w[8:7] = cont; w[6] = q;
        w[22] = dst[4]; w[15:12] = dst[3:0];
        w[5] = src[4];  w[3:0] = src[3:0];
        return w;
    endfunction

    // Issue one operation with the consumer ready and capture its result
    task automatic run_op(input logic selw, input logic [31:0] word, input logic [1:0] c,
                          input logic [1:0] e, input logic q, input logic [127:0] d);
        @(negedge clk);
        in_sel_word = selw; in_word = word; in_region = c; in_esize = e;
        in_quad = q; in_data = d; in_valid = 1'b1; out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1, "R9 valid one cycle after accept", 128'(out_valid), 128'd1);
        r_data = out_data; r_undef = out_undef; r_dst = out_dst; r_src = out_src;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!out_valid && !out_undef && in_ready, "R12 reset flags",
            {125'd0, out_valid, out_undef, in_ready}, 128'd1);
        chk(out_data == '0, "R12 reset data", out_data, '0);
    endtask

    // Every legal pairing, both widths, two patterns, plus involution
    task automatic t_legal_all();
        logic [127:0] pats [2] = '{PAT_IDX, PAT_MIX};
        for (int p = 0; p < 2; p++)
            for (int ci = 0; ci < 3; ci++)
                for (int ei = 0; ei < 3; ei++)
                    for (int qi = 0; qi < 2; qi++) begin
                        logic [1:0] c = 2'(ci);
                        logic [1:0] e = 2'(ei);
                        logic [127:0] exp, first, back;
                        if (elem_bits(e) >= cont_bits(c)) continue;
                        exp = ref_rev(pats[p], c, e, qi[0]);
                        run_op(1'b0, 32'h0, c, e, qi[0], pats[p]);
                        first = r_data;
                        // R1 R2 R3 R4: routing per container/element pairing
                        chk(first == exp && !r_undef,
                            (ci == 2) ? "R1 halfword swap" : (ci == 1) ? "R2 word reverse" : "R3 doubleword reverse",
                            first, exp);
                        run_op(1'b0, 32'h0, c, e, qi[0], first);
                        back = qi[0] ? pats[p] : {64'd0, pats[p][63:0]};
                        chk(r_data == back, "R11 twice returns original", r_data, back);
                    end
    endtask

    // Known R1 value and R4 data independence on an all-ones/zeros pattern
    task automatic t_known_values();
        run_op(1'b0, 32'h0, 2'b10, 2'b00, 1'b1, PAT_IDX);
        chk(r_data == 128'h0e0f0c0d_0a0b0809_06070405_02030001, "R1 literal", r_data,
            128'h0e0f0c0d_0a0b0809_06070405_02030001);
        run_op(1'b0, 32'h0, 2'b00, 2'b10, 1'b1, 128'hffffffff_00000000_00000000_ffffffff);
        chk(r_data == 128'h00000000_ffffffff_ffffffff_00000000, "R4 data independent", r_data,
            128'h00000000_ffffffff_ffffffff_00000000);
    endtask

    // 64-bit operation ignores and zeroes the upper half
    task automatic t_half_width();
        logic [127:0] exp = ref_rev({64'h0, PAT_MIX[63:0]}, 2'b01, 2'b01, 1'b0);
        run_op(1'b0, 32'h0, 2'b01, 2'b01, 1'b0, {64'hffff_0000_1234_5678, PAT_MIX[63:0]});
        chk(r_data == exp, "R5 upper ignored and zero", r_data, exp);
    endtask

    // Word fields win over direct fields; register numbers decoded
    task automatic t_word_mode();
        logic [31:0]  w = mk_word(2'b01, 2'b00, 1'b1, 5'b10110, 5'b01001);
        logic [127:0] exp = ref_rev(PAT_IDX, 2'b00, 2'b01, 1'b1);
        run_op(1'b1, w, 2'b10, 2'b00, 1'b0, PAT_IDX);
        chk(r_data == exp && !r_undef, "R6 word fields used", r_data, exp);
        chk(r_dst == 5'b10110, "R7 destination number", 128'(r_dst), 128'(5'b10110));
        chk(r_src == 5'b01001, "R7 source number", 128'(r_src), 128'(5'b01001));
        w = mk_word(2'b00, 2'b11, 1'b1, 5'b00001, 5'b11110);
        run_op(1'b1, w, 2'b00, 2'b00, 1'b1, PAT_IDX);
        chk(r_undef && r_data == '0, "R6 reserved in word despite legal direct fields",
            {127'd0, r_undef}, 128'd1);
        chk(r_dst == 5'b00001 && r_src == 5'b11110, "R7 numbers second word",
            {118'd0, r_dst, r_src}, {118'd0, 5'b00001, 5'b11110});
    endtask

    // Unsupported combinations
    task automatic t_undef();
        logic [1:0] cs [5] = '{2'b11, 2'b00, 2'b10, 2'b01, 2'b10};
        logic [1:0] es [5] = '{2'b00, 2'b11, 2'b01, 2'b10, 2'b10};
        for (int i = 0; i < 5; i++) begin
            run_op(1'b0, 32'h0, cs[i], es[i], 1'b1, PAT_MIX);
            chk(r_undef && r_data == '0, "R8 undefined and zero", r_data, '0);
        end
    endtask

    // Backpressure: hold while stalled, replace on same-cycle take
    task automatic t_backpressure();
        logic [127:0] ea = ref_rev(PAT_IDX, 2'b00, 2'b00, 1'b1);
        logic [127:0] eb = ref_rev(PAT_MIX, 2'b01, 2'b00, 1'b1);
        @(negedge clk);
        in_sel_word = 1'b0; in_region = 2'b00; in_esize = 2'b00; in_quad = 1'b1;
        in_data = PAT_IDX; in_valid = 1'b1; out_ready = 1'b0;
        @(negedge clk);
        in_region = 2'b01; in_data = PAT_MIX;
        chk(out_valid && !in_ready, "R10 full blocks input", {126'd0, out_valid, in_ready}, 128'd2);
        @(negedge clk);
        chk(out_valid && out_data == ea, "R10 held under stall", out_data, ea);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid && out_data == eb, "R10 replaced on same-cycle take", out_data, eb);
        @(negedge clk);
        chk(!out_valid, "R10 drains when taken", 128'(out_valid), 128'd0);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_sel_word = 1'b0; in_word = '0;
        in_region = '0; in_esize = '0; in_quad = 1'b0; in_data = '0; out_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_known_values();
        t_legal_all();
        t_half_width();
        t_word_mode();
        t_undef();
        t_backpressure();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule